// File: doc/BRIEF.md
# Auto-Negotiation Progress and Link Error Status Register

This block is one 16-bit status word in the management register space of an Ethernet PHY. It keeps a record of the furthest point the auto-negotiation state machine has reached. It also keeps two sticky error flags for the 100 Mb/s receive path. One flag marks a lost receive signal and the other marks a PLL that failed to lock onto the incoming stream. The word is shaped for a management agent that polls it over an MDIO-style interface.

The progress record is a 4-bit ordered value. It is built from the live 3-bit state code, with the completion indication placed above it as the most significant bit. The record only moves upward. When software reads the word, it receives the highest value seen so far, and the record is then reloaded with the present live state. Each read therefore reports the peak reached since the previous read. The two error flags are latch-high: they stay set until the word is read.

Top module: `an_progress_status`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every bit of `rd_data` is 0.
- R2: The progress value is {complete, code[2:0]}. Bits 13:11 of `rd_data` carry code[2:0] and bit 4 carries complete. When `an_enable` is 1 and no read is taking place, the value captures the live value whenever the live value is strictly greater than the value held. The new value is visible one cycle later.
- R3: When `an_enable` is 1 and no read is taking place, a live value less than or equal to the held value leaves the progress fields unchanged.
- R4: While `an_done` is 1, the live value is complete=1 with code 000. This makes it the greatest value, so it overrides any code; it reads as bit 4 set with bits 13:11 clear.
- R5: During a cycle with `rd_strobe` high, `rd_data` shows the held value. On the following cycle the progress fields hold the live value that was present during the read, even if that value is lower.
- R6: Bit 10 (receive signal lost) sets one cycle after a `rx_loss_evt` pulse. It stays 1 until the cycle after a read, and then it clears.
- R7: Bit 9 (PLL lock error) sets one cycle after a `pll_lock_evt` pulse. It stays 1 until the cycle after a read, and then it clears.
- R8: A read returns the flag values from before the clear. If an error event arrives in the same cycle as a read, the flag is still set afterwards.
- R9: While `speed_100` is 0, bits 10 and 9 read as 0 and their events are ignored. After a return to 100 Mb/s with no new event, they still read 0.
- R10: While `an_enable` is 0, the progress fields (bits 13:11 and 4) read 0 and do not change, reads included.
- R11: Bits 15:14, 8:5 and 3:0 of `rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| an_enable | input | 1 | Auto-negotiation enabled |
| speed_100 | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| live_code | input | 3 | Present auto-negotiation state code |
| an_done | input | 1 | Negotiation completed successfully |
| rx_loss_evt | input | 1 | Pulse: 100 Mb/s receive signal lost |
| pll_lock_evt | input | 1 | Pulse: PLL failed to lock |
| rd_strobe | input | 1 | One-cycle management read of this word |
| rd_data | output | 16 | Register contents |

## Verification
The progress capture is driven with several kinds of live sequences: rising codes, a lower code, an equal code, and a completion that follows the highest code. Together these separate strict-greater capture from a simple latest-value copy and from a greater-or-equal compare. Reads are issued after the peak has already fallen back to a lower live state, so a reload to the live value can be told apart from a held peak or from a clear to zero. The flag checks place an event one cycle before a read and in the same cycle as a read, and they also toggle the speed mode, which separates plain clear-on-read, priority of the event, and masking in 10 Mb/s mode.

// File: rtl/an_progress_status.sv
module an_progress_status #(
  parameter int CODE_W   = 3,
  parameter int WORD_W   = 16,
  parameter int CODE_LSB = 11,
  parameter int RXL_BIT  = 10,
  parameter int PLL_BIT  = 9,
  parameter int DONE_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              an_enable,
  input  logic              speed_100,
  input  logic [CODE_W-1:0] live_code,
  input  logic              an_done,
  input  logic              rx_loss_evt,
  input  logic              pll_lock_evt,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rd_data
);

  localparam int PROG_W = CODE_W + 1;

  logic [PROG_W-1:0] prog_q;
  logic [PROG_W-1:0] live_val;
  logic              rxl_q;
  logic              pll_q;

  assign live_val = an_done ? {1'b1, {CODE_W{1'b0}}} : {1'b0, live_code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prog_q <= '0;
    else if (!an_enable)
      prog_q <= '0;
    else if (rd_strobe || (live_val > prog_q))
      prog_q <= live_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxl_q <= 1'b0;
      pll_q <= 1'b0;
    end else begin
      rxl_q <= speed_100 & (rx_loss_evt  | (rxl_q & ~rd_strobe));
      pll_q <= speed_100 & (pll_lock_evt | (pll_q & ~rd_strobe));
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[CODE_LSB +: CODE_W] = prog_q[CODE_W-1:0];
    rd_data[DONE_BIT]           = prog_q[CODE_W];
    rd_data[RXL_BIT]            = rxl_q & speed_100;
    rd_data[PLL_BIT]            = pll_q & speed_100;
  end

  a_r2_capture_greater: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && !rd_strobe && (live_val > prog_q)) |=> (prog_q == $past(live_val)));

  a_r3_keep_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && !rd_strobe && (live_val <= prog_q)) |=> $stable(prog_q));

  a_r5_read_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && rd_strobe) |=> (prog_q == $past(live_val)));

  a_r6_rxl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_100 && rxl_q && !rd_strobe) |=> rxl_q);

  a_r7_pll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_100 && pll_q && !rd_strobe) |=> pll_q);

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (speed_100 && rx_loss_evt && pll_lock_evt) |=> (rxl_q && pll_q));

  a_r9_slow_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_100 |=> (!rxl_q && !pll_q));

  a_r10_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !an_enable |=> (prog_q == '0));

endmodule

// File: tb/test_an_progress_status.sv
module test_an_progress_status;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] UNUSED_MASK = 16'hC1EF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_enable = 1'b0;
  logic        speed_100 = 1'b1;
  logic [2:0]  live_code = 3'd0;
  logic        an_done = 1'b0;
  logic        rx_loss_evt = 1'b0;
  logic        pll_lock_evt = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  an_progress_status i_an_progress_status (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .speed_100(speed_100),
    .live_code(live_code), .an_done(an_done), .rx_loss_evt(rx_loss_evt),
    .pll_lock_evt(pll_lock_evt), .rd_strobe(rd_strobe), .rd_data(rd_data)
  );

  function automatic logic [15:0] prog_word(input logic done, input logic [2:0] code);
    return {2'b00, code, 6'b0, done, 4'b0};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R1 during reset", rd_data, 16'h0000);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 after release", rd_data, 16'h0000);
    check("R11 unused after reset", rd_data & UNUSED_MASK, 16'h0000);
  endtask

  task automatic t_progress();
    an_enable = 1'b1;
    live_code = 3'd3; tick();
    check("R2 capture 3", rd_data, prog_word(0, 3'd3));
    live_code = 3'd1; tick();
    check("R3 lower kept", rd_data, prog_word(0, 3'd3));
    live_code = 3'd3; tick();
    check("R3 equal kept", rd_data, prog_word(0, 3'd3));
    live_code = 3'd6; tick();
    check("R2 capture 6", rd_data, prog_word(0, 3'd6));
    live_code = 3'd7; tick();
    check("R2 capture 7", rd_data, prog_word(0, 3'd7));
    an_done = 1'b1; live_code = 3'd0; tick();
    check("R4 completion greatest", rd_data, prog_word(1, 3'd0));
    an_done = 1'b0; live_code = 3'd5; tick();
    check("R3 after completion kept", rd_data, prog_word(1, 3'd0));
  endtask

  task automatic t_read();
    live_code = 3'd2; rd_strobe = 1'b1;
    #1 check("R5 read returns peak", rd_data, prog_word(1, 3'd0));
    tick();
    rd_strobe = 1'b0;
    check("R5 reload live 2", rd_data, prog_word(0, 3'd2));
    live_code = 3'd0; rd_strobe = 1'b1;
    #1 check("R5 second read", rd_data, prog_word(0, 3'd2));
    tick();
    rd_strobe = 1'b0;
    check("R5 reload live 0", rd_data, 16'h0000);
  endtask

  task automatic t_flags();
    speed_100 = 1'b1; live_code = 3'd0;
    rx_loss_evt = 1'b1; tick(); rx_loss_evt = 1'b0;
    check("R6 rx flag set", rd_data, 16'h0400);
    tick(); tick();
    check("R6 rx flag held", rd_data, 16'h0400);
    rd_strobe = 1'b1;
    #1 check("R8 read shows pre-clear rx", rd_data, 16'h0400);
    tick(); rd_strobe = 1'b0;
    check("R6 rx cleared by read", rd_data, 16'h0000);
    pll_lock_evt = 1'b1; tick(); pll_lock_evt = 1'b0;
    check("R7 pll flag set", rd_data, 16'h0200);
    tick();
    check("R7 pll flag held", rd_data, 16'h0200);
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0;
    check("R7 pll cleared by read", rd_data, 16'h0000);
    rx_loss_evt = 1'b1; tick();
    rd_strobe = 1'b1;
    #1 check("R8 read before coincident event", rd_data, 16'h0400);
    tick(); rx_loss_evt = 1'b0; rd_strobe = 1'b0;
    check("R8 coincident event wins", rd_data, 16'h0400);
    pll_lock_evt = 1'b1; live_code = 3'd7; tick(); pll_lock_evt = 1'b0;
    check("R11 unused with all set", rd_data & UNUSED_MASK, 16'h0000);
    check("R2 all fields set", rd_data, 16'h0400 | 16'h0200 | prog_word(0, 3'd7));
    rd_strobe = 1'b1; live_code = 3'd0; tick(); rd_strobe = 1'b0;
    check("R6 full clear", rd_data, 16'h0000);
  endtask

  task automatic t_slow_mode();
    rx_loss_evt = 1'b1; tick(); rx_loss_evt = 1'b0;
    speed_100 = 1'b0;
    #1 check("R9 masked in 10M", rd_data, 16'h0000);
    rx_loss_evt = 1'b1; pll_lock_evt = 1'b1; tick();
    rx_loss_evt = 1'b0; pll_lock_evt = 1'b0;
    check("R9 events ignored", rd_data, 16'h0000);
    speed_100 = 1'b1; tick();
    check("R9 stays clear back at 100M", rd_data, 16'h0000);
  endtask

  task automatic t_an_off();
    live_code = 3'd4; tick();
    check("R2 capture 4", rd_data, prog_word(0, 3'd4));
    an_enable = 1'b0; live_code = 3'd6; tick();
    check("R10 disabled clears", rd_data, 16'h0000);
    an_done = 1'b1; tick();
    check("R10 no update disabled", rd_data, 16'h0000);
    rd_strobe = 1'b1; tick(); rd_strobe = 1'b0; an_done = 1'b0;
    check("R10 read while disabled", rd_data, 16'h0000);
    an_enable = 1'b1; live_code = 3'd1; tick();
    check("R2 resumes after enable", rd_data, prog_word(0, 3'd1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_progress();
    t_read();
    t_flags();
    t_slow_mode();
    t_an_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule